// File: doc/BRIEF.md
# External Memory Download Port

This peripheral lets firmware load and inspect an external parallel memory (static RAM, NOR flash or mask ROM) through three byte-wide registers. A loader running from internal program space points a 24-bit address counter at the target location and moves bytes through a data register. It drives the read and write strobes itself by setting and clearing bits in a control register. When the transfer is done, firmware hands the memory bus back to the CPU fetch path by clearing the bus-select bit.

The 24-bit address is loaded through a single register address. Successive accesses to that register reach the low, middle and page bytes in turn, and then return to the low byte. Any access to the data register sends that turn order back to the low byte and steps the address counter forward by one. A burst of transfers therefore needs the address to be set up only once.

Top module: `xmem_dl_port`

## Requirements
- R1: After reset the download bus is deselected (`mem_dl_sel` = 0), no data is driven (`mem_dout_en` = 0), and the address counter reads back as 0x00 in all three bytes.
- R2: Writes to register select 0 fill the address counter in the order low byte (bits 7..0), middle byte (bits 15..8), page byte (bits 23..16), and then return to the low byte.
- R3: A read or a write of register select 2 (data) returns the byte order to the low byte for the next access to select 0.
- R4: Each read or write of register select 2 increases the address counter by exactly one on that clock edge.
- R5: The address counter wraps from 0xFFFFFF to 0x000000.
- R6: Register select 1 (control) is write-only and reads as 0x00. Bit 2 selects the download bus, bit 1 drives the read strobe, bit 0 drives the write strobe, and bits 7..3 have no effect. A bit value of 0 asserts its active-low strobe. The reset value is binary 011.
- R7: While the download bit is 0, `mem_addr`, `mem_oe_n` and `mem_we_n` follow `cpu_addr`, `cpu_oe_n` and `cpu_we_n`.
- R8: A write to select 2 latches the byte. The byte is driven on `mem_dout`, with `mem_dout_en` = 1, only while the download bit is 1 and the write-control bit is 0. While the download bit is 1, `mem_addr` shows the address counter.
- R9: A read of select 2 returns the value present on `mem_din` in that cycle.
- R10: Reads of select 0 return the address byte at the current position of the byte order, and each read advances the order in the same way a write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 address, 1 control, 2 data |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle of `reg_rd` |
| cpu_addr | input | 24 | Fetch-side memory address |
| cpu_oe_n | input | 1 | Fetch-side output enable, active low |
| cpu_we_n | input | 1 | Fetch-side write enable, active low |
| mem_addr | output | 24 | Address to external memory |
| mem_dout | output | 8 | Data to external memory |
| mem_dout_en | output | 1 | Data output enable for the memory data pins |
| mem_din | input | 8 | Data from external memory |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dl_sel | output | 1 | High while the download bus owns the memory |

## Verification
The bench checks that a data access in the middle of the byte order brings it back to the low byte. A design that ignored this would write the next address byte into the middle byte. It also checks the byte order running past the page byte, where a faulty counter would write a fourth slot or stop. The address is walked through 0xFFFFFF, where a counter that saturates or carries wrongly would show a nonzero byte. The strobes and the data driver are checked with junk in the upper control bits and with download off, where a design that decoded the wrong bits would drive the memory bus during CPU fetch.

// File: rtl/xmem_dl_pkg.sv
package xmem_dl_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  localparam int unsigned CTL_BIT_WE = 0;
  localparam int unsigned CTL_BIT_OE = 1;
  localparam int unsigned CTL_BIT_DL = 2;
  localparam int unsigned CTL_W      = 3;
  localparam logic [CTL_W-1:0] CTL_RESET = 3'b011;

endpackage

// File: rtl/xmem_addr_ctr.sv
module xmem_addr_ctr #(
  parameter int unsigned N_BYTES = 3,
  parameter int unsigned BW      = 8,
  localparam int unsigned AW     = N_BYTES * BW,
  localparam int unsigned PTR_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_wr,
  input  logic             port_rd,
  input  logic [BW-1:0]    wdata,
  input  logic             step,
  output logic [AW-1:0]    addr,
  output logic [BW-1:0]    rd_byte,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_BYTES - 1);

  logic [AW-1:0]    addr_q, addr_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             port_acc;
  logic             upd_en;

  assign port_acc = port_wr | port_rd;
  assign upd_en   = step | port_acc;

  always_comb begin
    addr_d = addr_q;
    ptr_d  = ptr_q;
    if (step) begin
      addr_d = addr_q + AW'(1);
      ptr_d  = '0;
    end else if (port_acc) begin
      if (port_wr) begin
        for (int i = 0; i < int'(N_BYTES); i++) begin
          if (ptr_q == PTR_W'(i)) begin
            addr_d[i*BW +: BW] = wdata;
          end
        end
      end
      ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < int'(N_BYTES); i++) begin
      if (ptr_q == PTR_W'(i)) begin
        rd_byte = addr_q[i*BW +: BW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ptr_q  <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      ptr_q  <= ptr_d;
    end
  end

  assign addr = addr_q;
  assign ptr  = ptr_q;

endmodule

// File: rtl/xmem_ctrl_reg.sv
module xmem_ctrl_reg
  import xmem_dl_pkg::*;
#(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wdata,
  output logic          dl_on,
  output logic          oe_ctl,
  output logic          we_ctl
);

  logic [CTL_W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
    end else if (wr_en) begin
      ctl_q <= ctl_d;
    end
  end

  assign dl_on  = ctl_q[CTL_BIT_DL];
  assign oe_ctl = ctl_q[CTL_BIT_OE];
  assign we_ctl = ctl_q[CTL_BIT_WE];

endmodule

// File: rtl/xmem_bus_mux.sv
module xmem_bus_mux #(
  parameter int unsigned AW = 24,
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [BW-1:0] wdata,
  input  logic          dl_on,
  input  logic          oe_ctl,
  input  logic          we_ctl,
  input  logic [AW-1:0] ctr_addr,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_oe_n,
  input  logic          cpu_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_dout,
  output logic          mem_dout_en,
  output logic          mem_oe_n,
  output logic          mem_we_n
);

  logic [BW-1:0] dat_q, dat_d;

  always_comb begin
    dat_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (data_wr) begin
      dat_q <= dat_d;
    end
  end

  always_comb begin
    if (dl_on) begin
      mem_addr = ctr_addr;
      mem_oe_n = oe_ctl;
      mem_we_n = we_ctl;
    end else begin
      mem_addr = cpu_addr;
      mem_oe_n = cpu_oe_n;
      mem_we_n = cpu_we_n;
    end
    mem_dout_en = dl_on & ~we_ctl;
    mem_dout    = dat_q;
  end

endmodule

// File: rtl/xmem_dl_port.sv
module xmem_dl_port
  import xmem_dl_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  parameter int unsigned BYTE_W     = 8,
  localparam int unsigned AW        = ADDR_BYTES * BYTE_W,
  localparam int unsigned PTR_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_oe_n,
  input  logic              cpu_we_n,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [BYTE_W-1:0] mem_din,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dl_sel
);

  logic              sel_addr, sel_ctrl, sel_data;
  logic              ac_wr, ac_rd, data_acc, data_wr, ctl_wr;
  logic [AW-1:0]     ac_addr;
  logic [BYTE_W-1:0] ac_byte;
  logic [PTR_W-1:0]  ac_ptr;
  logic              dl_on, oe_ctl, we_ctl;

  assign sel_addr = (reg_sel == SEL_ADDR);
  assign sel_ctrl = (reg_sel == SEL_CTRL);
  assign sel_data = (reg_sel == SEL_DATA);

  assign ac_wr    = sel_addr & reg_wr;
  assign ac_rd    = sel_addr & reg_rd & ~reg_wr;
  assign ctl_wr   = sel_ctrl & reg_wr;
  assign data_wr  = sel_data & reg_wr;
  assign data_acc = sel_data & (reg_wr | reg_rd);

  xmem_addr_ctr #(.N_BYTES(ADDR_BYTES), .BW(BYTE_W)) u_ac (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_wr (ac_wr),
    .port_rd (ac_rd),
    .wdata   (reg_wdata),
    .step    (data_acc),
    .addr    (ac_addr),
    .rd_byte (ac_byte),
    .ptr     (ac_ptr)
  );

  xmem_ctrl_reg #(.BW(BYTE_W)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctl_wr),
    .wdata  (reg_wdata),
    .dl_on  (dl_on),
    .oe_ctl (oe_ctl),
    .we_ctl (we_ctl)
  );

  xmem_bus_mux #(.AW(AW), .BW(BYTE_W)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_wr     (data_wr),
    .wdata       (reg_wdata),
    .dl_on       (dl_on),
    .oe_ctl      (oe_ctl),
    .we_ctl      (we_ctl),
    .ctr_addr    (ac_addr),
    .cpu_addr    (cpu_addr),
    .cpu_oe_n    (cpu_oe_n),
    .cpu_we_n    (cpu_we_n),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n)
  );

  always_comb begin
    unique case (1'b1)
      sel_addr: reg_rdata = ac_byte;
      sel_data: reg_rdata = mem_din;
      default:  reg_rdata = '0;
    endcase
  end

  assign mem_dl_sel = dl_on;

endmodule

// File: rtl/xmem_dl_port_chk.sv
module xmem_dl_port_chk #(
  parameter int unsigned AW     = 24,
  parameter int unsigned BW     = 8,
  parameter int unsigned NB     = 3,
  parameter int unsigned PTR_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_sel,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [BW-1:0]    reg_rdata,
  input logic [AW-1:0]    cpu_addr,
  input logic             cpu_oe_n,
  input logic             cpu_we_n,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_dout_en,
  input logic [BW-1:0]    mem_din,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic             mem_dl_sel,
  input logic [AW-1:0]    ac_addr,
  input logic [PTR_W-1:0] ac_ptr
);

  logic data_acc, addr_acc;
  assign data_acc = (reg_sel == 2'd2) && (reg_wr || reg_rd);
  assign addr_acc = (reg_sel == 2'd0) && (reg_wr || reg_rd);

  AST_ROT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_acc && ac_ptr == PTR_W'(NB - 1)) |=> (ac_ptr == '0)); // R2

  AST_ROT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> (ac_ptr == '0)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> (ac_addr == $past(ac_addr) + AW'(1))); // R4

  AST_FETCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_dl_sel |-> (mem_addr == cpu_addr && mem_oe_n == cpu_oe_n && mem_we_n == cpu_we_n)); // R7

  AST_DRIVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (mem_dl_sel && !mem_we_n)); // R8

  AST_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2 && reg_rd && !reg_wr) |-> (reg_rdata == mem_din)); // R9

endmodule

bind xmem_dl_port xmem_dl_port_chk #(
  .AW(AW), .BW(BYTE_W), .NB(ADDR_BYTES), .PTR_W(PTR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_sel     (reg_sel),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_rdata   (reg_rdata),
  .cpu_addr    (cpu_addr),
  .cpu_oe_n    (cpu_oe_n),
  .cpu_we_n    (cpu_we_n),
  .mem_addr    (mem_addr),
  .mem_dout_en (mem_dout_en),
  .mem_din     (mem_din),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_dl_sel  (mem_dl_sel),
  .ac_addr     (ac_addr),
  .ac_ptr      (ac_ptr)
);

// File: tb/xmem_dl_port_tb.sv
module xmem_dl_port_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [23:0] cpu_addr, mem_addr;
  logic        cpu_oe_n, cpu_we_n;
  logic [7:0]  mem_dout, mem_din;
  logic        mem_dout_en, mem_oe_n, mem_we_n, mem_dl_sel;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  xmem_dl_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .cpu_oe_n(cpu_oe_n), .cpu_we_n(cpu_we_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dl_sel(mem_dl_sel)
  );

  // entry = {is_read, sel[1:0], byte}: write data for writes, expected data for reads
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 2'd2, 8'hA5},  // data read: R9, order back to low
    {1'b0, 2'd0, 8'h11},  // low byte
    {1'b0, 2'd0, 8'h22},  // middle byte
    {1'b0, 2'd0, 8'h33},  // page byte
    {1'b1, 2'd0, 8'h11},  // R10 readback and R2 order
    {1'b1, 2'd0, 8'h22},
    {1'b1, 2'd0, 8'h33},
    {1'b1, 2'd0, 8'h11},  // R2 order returns to low
    {1'b1, 2'd2, 8'hA5},  // R9, R4 step to 0x332212, R3 clear
    {1'b1, 2'd0, 8'h12},  // R3 low byte next, R4 incremented
    {1'b1, 2'd0, 8'h22},
    {1'b0, 2'd2, 8'h3C},  // data write mid-order: 0x332213, order cleared
    {1'b1, 2'd0, 8'h13},  // R3 and R4
    {1'b1, 2'd1, 8'h00}   // R6 control reads as zero
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic rd, input logic [1:0] sel, input logic [7:0] d, input string tag);
    @(negedge clk);
    reg_sel   = sel;
    reg_wr    = !rd;
    reg_rd    = rd;
    reg_wdata = rd ? 8'h00 : d;
    #1;
    if (rd) chk(tag, 32'(reg_rdata), 32'(d));
  endtask

  task automatic idle();
    @(negedge clk);
    reg_wr = 1'b0;
    reg_rd = 1'b0;
    #1;
  endtask

  initial begin
    #800000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    cpu_addr = 24'h123456; cpu_oe_n = 1'b0; cpu_we_n = 1'b1; mem_din = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 dl_sel after reset", 32'(mem_dl_sel), 32'd0);
    chk("R1 dout_en after reset", 32'(mem_dout_en), 32'd0);
    chk("R7 addr from cpu", 32'(mem_addr), 32'h123456);
    chk("R7 oe_n from cpu", 32'(mem_oe_n), 32'd0);
    chk("R7 we_n from cpu", 32'(mem_we_n), 32'd1);
    acc(1'b1, 2'd0, 8'h00, "R1 reset low byte");
    acc(1'b1, 2'd0, 8'h00, "R1 reset middle byte");
    acc(1'b1, 2'd0, 8'h00, "R1 reset page byte");

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][10], VEC[i][9:8], VEC[i][7:0], "R2 R3 R4 R9 R10 table");
    end
    idle();

    // R6 R8: download on, write strobe asserted, data driven
    acc(1'b0, 2'd1, 8'h06, "");
    idle();
    chk("R6 dl bit", 32'(mem_dl_sel), 32'd1);
    chk("R6 we strobe low", 32'(mem_we_n), 32'd0);
    chk("R6 oe strobe high", 32'(mem_oe_n), 32'd1);
    chk("R8 dout enabled", 32'(mem_dout_en), 32'd1);
    chk("R8 latched data", 32'(mem_dout), 32'h3C);
    chk("R8 counter on bus", 32'(mem_addr), 32'h332213);

    // R6: upper bits ignored, read strobe asserted
    acc(1'b0, 2'd1, 8'hFD, "");
    idle();
    chk("R6 upper bits ignored dl", 32'(mem_dl_sel), 32'd1);
    chk("R6 oe strobe low", 32'(mem_oe_n), 32'd0);
    chk("R6 we strobe high", 32'(mem_we_n), 32'd1);
    chk("R8 dout off with we high", 32'(mem_dout_en), 32'd0);

    // R7: download off, junk upper bits, fetch path owns the bus
    acc(1'b0, 2'd1, 8'hF0, "");
    idle();
    cpu_addr = 24'hABCDEF; cpu_oe_n = 1'b1; cpu_we_n = 1'b0;
    #1;
    chk("R7 dl off", 32'(mem_dl_sel), 32'd0);
    chk("R7 addr follows cpu", 32'(mem_addr), 32'hABCDEF);
    chk("R7 we_n follows cpu", 32'(mem_we_n), 32'd0);
    chk("R8 no drive with dl off", 32'(mem_dout_en), 32'd0);

    // R5: wrap at the top of the address space
    acc(1'b1, 2'd2, 8'hA5, "R9 data read before wrap");
    acc(1'b0, 2'd0, 8'hFF, "");
    acc(1'b0, 2'd0, 8'hFF, "");
    acc(1'b0, 2'd0, 8'hFF, "");
    acc(1'b1, 2'd2, 8'hA5, "R9 data read at top");
    acc(1'b1, 2'd0, 8'h00, "R5 wrap low byte");
    acc(1'b1, 2'd0, 8'h00, "R5 wrap middle byte");
    acc(1'b1, 2'd0, 8'h00, "R5 wrap page byte");
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule